// File: doc/BRIEF.md
# Interrupt Status Collector and Host Read Arbiter

This block gathers five device events into one status byte and signals an external host processor through an active-low interrupt line. Each event has its own enable bit. An event sets its status bit only while that enable is set. The interrupt line is low for as long as any enabled status bit is set.

The block also owns the byte the host receives on its read strobe. When the host starts a register read while an interrupt is pending, the next strobe returns the status byte instead of the register data. The `host_ready` output is held low while that status byte is on offer, so the host can tell which kind of byte it received. Once the status byte has been taken, the read carries on and the register byte follows.

Events that arrive after a read has started are parked until the register byte has been delivered. Two streams use valid/ready. The register data arriving from the register file moves on a beat where `reg_vld` and `reg_rdy` are both high. The byte going out to the host moves on a beat where `host_vld` and `host_rd` are both high; `host_rd` is the host's read strobe. While a byte is offered and not taken, it stays offered. The host may stall without limit.

Top module: `irq_rd_arbiter`

## Requirements
- R1: Status byte layout: bit 6 = endpoint-0 buffer available, bit 5 = OUT FIFO flag change, bit 2 = enumeration complete, bit 1 = bus activity change, bit 0 = ready. Bits 7, 4 and 3 always read as 0. The effective enable mask is `evt_en` restricted to those five positions.
- R2: An event whose enable bit is clear sets no status bit, and it leaves `irq_n` and `host_vld` unchanged.
- R3: Any `fifo_empty` bit that changes in either direction sets bit 5. The first cycle after reset only samples the flags and raises no event.
- R4: `bus_active` changing in either direction sets bit 1. The first cycle after reset raises no event.
- R5: A `selftest_done` pulse sets bit 0 when `cfg_desc_valid` is low, and sets bit 2 instead when it is high. A `wake_pulse` sets bit 0.
- R6: An `enum_done` pulse sets bit 2 only while enumeration is armed. Arming is set by reset and by a `bus_reset` pulse. Arming is consumed by the enumeration-complete event from either source.
- R7: `irq_n` is low exactly when some enabled status bit is set. While no read is in progress, such a status byte is offered on `host_data` with `host_vld` high.
- R8: A `cmd_rd` pulse while an interrupt is pending first offers the status byte with `host_ready` low. After the host takes that byte, the register byte is offered with `host_ready` high.
- R9: A `cmd_rd` pulse with no interrupt pending keeps `host_vld` low until the register byte has been accepted. The register byte is then offered with `host_ready` high.
- R10: Events that occur after a read has started do not drive `irq_n` or the status byte until the register byte has been taken. They then appear together.
- R11: Taking the status byte clears every bit it reported. An event in the same cycle is kept.
- R12: An offered register byte stays stable until taken. `reg_rdy` is high only while the read waits for data with its one-byte buffer empty. `cmd_rd` is ignored while a read is in progress.
- R13: A synchronous active-low `rst_n` clears all status, held events and read state. Afterwards `irq_n` is high, `host_vld` is low and `host_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_en | input | 8 | Per-bit event enables, same positions as the status byte |
| ep0_buf_pulse | input | 1 | Endpoint-0 buffer became available |
| selftest_done | input | 1 | Power-up self-test finished |
| wake_pulse | input | 1 | Woken from low power by the wakeup input |
| cfg_desc_valid | input | 1 | A valid configuration descriptor was loaded at power-up |
| enum_done | input | 1 | Enumeration finished |
| bus_reset | input | 1 | Bus reset seen; re-arms enumeration |
| bus_active | input | 1 | Bus activity level |
| fifo_empty | input | NUM_FIFO | Empty flags of the monitored OUT FIFOs |
| cmd_rd | input | 1 | Host started a register read |
| reg_data | input | 8 | Register byte from the register file |
| reg_vld | input | 1 | reg_data is valid |
| reg_rdy | output | 1 | Block can accept reg_data |
| host_data | output | 8 | Byte offered to the host |
| host_vld | output | 1 | host_data is valid |
| host_rd | input | 1 | Host read strobe |
| host_ready | output | 1 | Low while a status byte is offered ahead of a read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Directed patterns fire each event alone with its enable set and then cleared. This separates bit placement from enable gating. Flag and bus transitions are driven in both directions to show that both edges count. Self-test is run with and without a valid descriptor, and `enum_done` is repeated with and without an intervening bus reset; these separate the ready path from the enumeration path and show the arming. Reads are started with an interrupt pending, without one, and with events landing mid-read. These distinguish preemption, plain reads and deferral. A long random run then mixes every input, including stalled strobes, against a cycle model kept in the bench.

// File: rtl/irq_rd_pkg.sv
`timescale 1ns/1ps
package irq_rd_pkg;
  localparam int BYTE_W = 8;

  // status byte bit positions (host software decodes these)
  localparam int B_EP0  = 6;
  localparam int B_FLAG = 5;
  localparam int B_ENUM = 2;
  localparam int B_BUS  = 1;
  localparam int B_RDY  = 0;

  localparam logic [BYTE_W-1:0] LIVE_MASK =
    BYTE_W'((1 << B_EP0) | (1 << B_FLAG) | (1 << B_ENUM) | (1 << B_BUS) | (1 << B_RDY));

  typedef enum logic [1:0] {
    RD_IDLE    = 2'd0,
    RD_PREEMPT = 2'd1,
    RD_WAIT    = 2'd2,
    RD_DATA    = 2'd3
  } rd_state_e;
endpackage

// File: rtl/irq_evt_gen.sv
`timescale 1ns/1ps
module irq_evt_gen
  import irq_rd_pkg::*;
#(
  parameter int NUM_FIFO = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ep0_buf_pulse,
  input  logic                selftest_done,
  input  logic                wake_pulse,
  input  logic                cfg_desc_valid,
  input  logic                enum_done,
  input  logic                bus_reset,
  input  logic                bus_active,
  input  logic [NUM_FIFO-1:0] fifo_empty,
  output logic [BYTE_W-1:0]   raw_evt
);
  logic                primed_q;
  logic                bus_q;
  logic                armed_q;
  logic [NUM_FIFO-1:0] fifo_q;
  logic [NUM_FIFO-1:0] fifo_chg;
  logic                flag_evt;
  logic                bus_evt;
  logic                enum_evt;
  logic                rdy_evt;

  // per-FIFO edge detect, either direction, gated until flags are first sampled
  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo_edge
    assign fifo_chg[g] = primed_q & (fifo_empty[g] ^ fifo_q[g]);
  end

  assign flag_evt = |fifo_chg;
  assign bus_evt  = primed_q & (bus_active ^ bus_q);
  assign enum_evt = (selftest_done & cfg_desc_valid) | (enum_done & armed_q);
  assign rdy_evt  = (selftest_done & ~cfg_desc_valid) | wake_pulse;

  always_comb begin
    raw_evt         = '0;
    raw_evt[B_EP0]  = ep0_buf_pulse;
    raw_evt[B_FLAG] = flag_evt;
    raw_evt[B_ENUM] = enum_evt;
    raw_evt[B_BUS]  = bus_evt;
    raw_evt[B_RDY]  = rdy_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      bus_q    <= 1'b0;
      fifo_q   <= '0;
      armed_q  <= 1'b1;
    end else begin
      primed_q <= 1'b1;
      bus_q    <= bus_active;
      fifo_q   <= fifo_empty;
      if (bus_reset)     armed_q <= 1'b1;
      else if (enum_evt) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg
  import irq_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] new_evt,
  input  logic              defer,
  input  logic              merge,
  input  logic              clr_en,
  input  logic [BYTE_W-1:0] clr_mask,
  output logic [BYTE_W-1:0] status_q
);
  logic [BYTE_W-1:0] held_q;
  logic [BYTE_W-1:0] to_status;
  logic [BYTE_W-1:0] to_held;
  logic [BYTE_W-1:0] kept;

  always_comb begin
    to_status = '0;
    to_held   = '0;
    if (!defer)     to_status = new_evt;
    else if (merge) to_status = new_evt | held_q;
    else            to_held   = new_evt;
    kept = clr_en ? (status_q & ~clr_mask) : status_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      held_q   <= '0;
    end else begin
      status_q <= kept | to_status;
      held_q   <= merge ? '0 : (held_q | to_held);
    end
  end
endmodule

// File: rtl/irq_rd_fsm.sv
`timescale 1ns/1ps
module irq_rd_fsm
  import irq_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              pend,
  input  logic [BYTE_W-1:0] stat_byte,
  input  logic [BYTE_W-1:0] reg_data,
  input  logic              reg_vld,
  output logic              reg_rdy,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] host_data,
  output logic              host_vld,
  output logic              host_ready,
  output logic              defer,
  output logic              merge,
  output logic              clr_en,
  output logic [BYTE_W-1:0] clr_mask,
  output logic [1:0]        state_o
);
  rd_state_e         state_q, state_d;
  logic              full_q;
  logic [BYTE_W-1:0] buf_q;
  logic              xfer;
  logic              acc;

  assign reg_rdy = ((state_q == RD_PREEMPT) || (state_q == RD_WAIT)) && !full_q;
  assign acc     = reg_vld & reg_rdy;

  always_comb begin
    case (state_q)
      RD_IDLE:    host_vld = pend;
      RD_PREEMPT: host_vld = 1'b1;
      RD_WAIT:    host_vld = 1'b0;
      default:    host_vld = 1'b1;
    endcase
    host_data = (state_q == RD_DATA) ? buf_q : stat_byte;
  end

  assign xfer       = host_vld & host_rd;
  assign host_ready = (state_q != RD_PREEMPT);
  assign defer      = (state_q != RD_IDLE);
  assign merge      = (state_q == RD_DATA) & xfer;
  assign clr_en     = xfer & ((state_q == RD_IDLE) || (state_q == RD_PREEMPT));
  assign clr_mask   = stat_byte;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE:    if (cmd_rd) state_d = (pend && !xfer) ? RD_PREEMPT : RD_WAIT;
      RD_PREEMPT: if (xfer)   state_d = (full_q || acc) ? RD_DATA : RD_WAIT;
      RD_WAIT:    if (acc)    state_d = RD_DATA;
      default:    if (xfer)   state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      full_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (acc) begin
        full_q <= 1'b1;
        buf_q  <= reg_data;
      end else if (merge) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_rd_arbiter.sv
`timescale 1ns/1ps
module irq_rd_arbiter
  import irq_rd_pkg::*;
#(
  parameter int NUM_FIFO = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          evt_en,
  input  logic                ep0_buf_pulse,
  input  logic                selftest_done,
  input  logic                wake_pulse,
  input  logic                cfg_desc_valid,
  input  logic                enum_done,
  input  logic                bus_reset,
  input  logic                bus_active,
  input  logic [NUM_FIFO-1:0] fifo_empty,
  input  logic                cmd_rd,
  input  logic [7:0]          reg_data,
  input  logic                reg_vld,
  output logic                reg_rdy,
  output logic [7:0]          host_data,
  output logic                host_vld,
  input  logic                host_rd,
  output logic                host_ready,
  output logic                irq_n
);
  logic [BYTE_W-1:0] en_m;
  logic [BYTE_W-1:0] raw_evt;
  logic [BYTE_W-1:0] new_evt;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] clr_mask;
  logic              pend;
  logic              defer;
  logic              merge;
  logic              clr_en;
  logic [1:0]        arb_state;

  assign en_m    = evt_en & LIVE_MASK;
  assign new_evt = raw_evt & en_m;
  assign pend    = |(status & en_m);
  assign irq_n   = ~pend;

  irq_evt_gen #(.NUM_FIFO(NUM_FIFO)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .ep0_buf_pulse(ep0_buf_pulse), .selftest_done(selftest_done),
    .wake_pulse(wake_pulse), .cfg_desc_valid(cfg_desc_valid),
    .enum_done(enum_done), .bus_reset(bus_reset),
    .bus_active(bus_active), .fifo_empty(fifo_empty),
    .raw_evt(raw_evt)
  );

  irq_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .new_evt(new_evt), .defer(defer),
    .merge(merge), .clr_en(clr_en), .clr_mask(clr_mask), .status_q(status)
  );

  irq_rd_fsm u_arb (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .pend(pend),
    .stat_byte(status), .reg_data(reg_data), .reg_vld(reg_vld),
    .reg_rdy(reg_rdy), .host_rd(host_rd), .host_data(host_data),
    .host_vld(host_vld), .host_ready(host_ready), .defer(defer),
    .merge(merge), .clr_en(clr_en), .clr_mask(clr_mask), .state_o(arb_state)
  );
endmodule

// File: rtl/irq_rd_arbiter_chk.sv
`timescale 1ns/1ps
module irq_rd_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_n,
  input logic       host_vld,
  input logic       host_rd,
  input logic       host_ready,
  input logic [7:0] host_data,
  input logic       reg_rdy,
  input logic [1:0] st
);
  // st encoding: 0 idle, 1 status ahead of read, 2 waiting for data, 3 data offered
  p_unused_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_vld && st != 2'd3) |-> ((host_data & 8'h98) == 8'h00));

  p_irq_offers_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !irq_n) |-> host_vld);

  p_preempt_offered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |-> host_vld);

  p_preempt_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && host_rd) |=> host_ready);

  p_hold_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && host_vld && !host_rd) |=> (host_vld && $stable(host_data)));

  p_regrdy_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdy |-> (st == 2'd1 || st == 2'd2));
endmodule

bind irq_rd_arbiter irq_rd_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .host_vld(host_vld),
  .host_rd(host_rd), .host_ready(host_ready), .host_data(host_data),
  .reg_rdy(reg_rdy), .st(arb_state)
);

// File: tb/irq_rd_arbiter_bench.sv
`timescale 1ns/1ps
module irq_rd_arbiter_bench;
  localparam int NF = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [7:0]    en = 8'h00;
  logic          ep0 = 0, std = 0, wake = 0, cfg = 0, endn = 0, bres = 0, bus = 0;
  logic [NF-1:0] fifo = '1;
  logic          cmd = 0, rvld = 0, hrd = 0;
  logic [7:0]    rdat = 8'h00;
  logic          rrdy, hvld, hready, irq_n;
  logic [7:0]    hdata;

  irq_rd_arbiter #(.NUM_FIFO(NF)) u_irq_rd_arbiter (
    .clk(clk), .rst_n(rst_n), .evt_en(en), .ep0_buf_pulse(ep0),
    .selftest_done(std), .wake_pulse(wake), .cfg_desc_valid(cfg),
    .enum_done(endn), .bus_reset(bres), .bus_active(bus), .fifo_empty(fifo),
    .cmd_rd(cmd), .reg_data(rdat), .reg_vld(rvld), .reg_rdy(rrdy),
    .host_data(hdata), .host_vld(hvld), .host_rd(hrd),
    .host_ready(hready), .irq_n(irq_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // cycle model: states 0 idle, 1 status ahead of read, 2 wait, 3 data
  logic [7:0]    m_stat, m_held, m_regq;
  int            m_st;
  bit            m_full, m_armed, m_primed, m_bus, m_live;
  logic [NF-1:0] m_fifo;

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_stat = 0; m_held = 0; m_regq = 0; m_st = 0;
    m_full = 0; m_armed = 1; m_primed = 0; m_bus = 0; m_fifo = '0;
  endtask

  function automatic logic [7:0] exp_mask();
    return en & 8'h67;
  endfunction

  function automatic bit exp_vld();
    case (m_st)
      0: return |(m_stat & exp_mask());
      1: return 1'b1;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step();
    logic [7:0] raw, nw, clr, ns, nh;
    bit ev, er, xfer, acc, defer, merge;
    int nst;
    #2;
    ev = exp_vld();
    er = (m_st == 1 || m_st == 2) && !m_full;
    if (m_live) begin
      chk8("R7 irq_n", {7'b0, irq_n}, {7'b0, ~(|(m_stat & exp_mask()))});
      chk8("R8 host_vld", {7'b0, hvld}, {7'b0, ev});
      if (ev) chk8("R11 host_data", hdata, (m_st == 3) ? m_regq : m_stat);
      chk8("R8 host_ready", {7'b0, hready}, {7'b0, m_st != 1});
      chk8("R12 reg_rdy", {7'b0, rrdy}, {7'b0, er});
    end
    raw = 0;
    raw[6] = ep0;
    raw[5] = m_primed && (fifo != m_fifo);
    raw[2] = (std && cfg) || (endn && m_armed);
    raw[1] = m_primed && (bus != m_bus);
    raw[0] = (std && !cfg) || wake;
    nw = raw & exp_mask();
    xfer = hrd && ev;
    acc = rvld && er;
    defer = (m_st != 0);
    merge = (m_st == 3) && xfer;
    clr = (xfer && (m_st == 0 || m_st == 1)) ? m_stat : 8'h00;
    ns = (m_stat & ~clr) | (defer ? (merge ? (nw | m_held) : 8'h00) : nw);
    nh = merge ? 8'h00 : (m_held | (defer ? nw : 8'h00));
    nst = m_st;
    case (m_st)
      0: if (cmd) nst = ((|(m_stat & exp_mask())) && !xfer) ? 1 : 2;
      1: if (xfer) nst = (m_full || acc) ? 3 : 2;
      2: if (acc) nst = 3;
      default: if (xfer) nst = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
    if (bres) m_armed = 1;
    else if (raw[2]) m_armed = 0;
    if (acc) begin m_full = 1; m_regq = rdat; end
    else if (merge) m_full = 0;
    m_stat = ns; m_held = nh; m_st = nst;
    m_primed = 1; m_fifo = fifo; m_bus = bus;
    ep0 = 0; std = 0; wake = 0; endn = 0; bres = 0; cmd = 0; rvld = 0; hrd = 0;
    #1;
  endtask

  task automatic do_reset();
    m_live = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    m_live = 1;
    #1;
  endtask

  task automatic take();
    hrd = 1; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    m_live = 0;
    @(negedge clk);
    do_reset();
    // R13: reset state
    chk8("R13 irq_n", {7'b0, irq_n}, 8'h01);
    chk8("R13 host_vld", {7'b0, hvld}, 8'h00);
    chk8("R13 host_ready", {7'b0, hready}, 8'h01);
    step();                       // priming cycle
    // R1 + R7: single event bit placement
    en = 8'hFF; ep0 = 1; step();
    chk8("R1 ep0 bit", hdata, 8'h40);
    chk8("R7 irq_n low", {7'b0, irq_n}, 8'h00);
    take();
    chk8("R11 cleared", {7'b0, irq_n}, 8'h01);
    // R2: disabled event ignored
    en = 8'h00; wake = 1; step();
    chk8("R2 irq_n", {7'b0, irq_n}, 8'h01);
    en = 8'hFF; step();
    chk8("R2 no bit left", {7'b0, hvld}, 8'h00);
    // R3: FIFO flag both directions
    fifo = 4'b1110; step();
    chk8("R3 to not empty", hdata, 8'h20);
    take();
    fifo = 4'b1111; step();
    chk8("R3 to empty", hdata, 8'h20);
    take();
    // R4: bus activity both directions
    bus = 1; step();
    chk8("R4 resume", hdata, 8'h02);
    take();
    bus = 0; step();
    chk8("R4 stop", hdata, 8'h02);
    take();
    // R5: ready vs enumeration on self-test
    cfg = 0; std = 1; step();
    chk8("R5 ready", hdata, 8'h01);
    take();
    cfg = 1; std = 1; step();
    chk8("R5 enum instead", hdata, 8'h04);
    take();
    // R6: arming
    endn = 1; step();
    chk8("R6 unarmed", {7'b0, irq_n}, 8'h01);
    bres = 1; step();
    endn = 1; step();
    chk8("R6 rearmed", hdata, 8'h04);
    take();
    // R1: all live bits together
    ep0 = 1; wake = 1; std = 1; cfg = 1; bus = 1; fifo = 4'b0111; step();
    chk8("R1 all bits", hdata, 8'h67);
    take();
    cfg = 0;
    // R8 + R10: preemption and deferral
    ep0 = 1; step();
    cmd = 1; step();
    chk8("R8 not ready", {7'b0, hready}, 8'h00);
    chk8("R8 status first", hdata, 8'h40);
    wake = 1; step();
    take();
    chk8("R10 held", {7'b0, irq_n}, 8'h01);
    rdat = 8'hA5; rvld = 1; step();
    chk8("R8 reg data", hdata, 8'hA5);
    chk8("R8 ready high", {7'b0, hready}, 8'h01);
    chk8("R10 still held", {7'b0, irq_n}, 8'h01);
    take();
    chk8("R10 released", hdata, 8'h01);
    chk8("R10 irq", {7'b0, irq_n}, 8'h00);
    take();
    // R9 + R12: plain read with stall
    cmd = 1; step();
    chk8("R9 waiting", {7'b0, hvld}, 8'h00);
    chk8("R12 reg_rdy", {7'b0, rrdy}, 8'h01);
    rdat = 8'h3C; rvld = 1; step();
    step(); step();
    cmd = 1; step();
    chk8("R12 stable", hdata, 8'h3C);
    chk8("R9 ready", {7'b0, hready}, 8'h01);
    take();
    chk8("R9 done", {7'b0, hvld}, 8'h00);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) en = 8'($urandom);
      ep0  = (($urandom % 16) == 0);
      std  = (($urandom % 32) == 0);
      wake = (($urandom % 32) == 0);
      if (($urandom % 64) == 0) cfg = ~cfg;
      endn = (($urandom % 16) == 0);
      bres = (($urandom % 32) == 0);
      if (($urandom % 20) == 0) bus = ~bus;
      if (($urandom % 8) == 0) fifo[$urandom % NF] = ~fifo[$urandom % NF];
      cmd  = (($urandom % 6) == 0);
      rvld = (($urandom % 3) == 0);
      rdat = 8'($urandom);
      hrd  = (($urandom % 2) == 0);
      step();
    end
    // R13: reset mid-activity
    ep0 = 1; en = 8'hFF; step();
    cmd = 1; step();
    do_reset();
    chk8("R13 irq_n", {7'b0, irq_n}, 8'h01);
    chk8("R13 host_vld", {7'b0, hvld}, 8'h00);
    chk8("R13 host_ready", {7'b0, hready}, 8'h01);
    chk8("R13 reg_rdy", {7'b0, rrdy}, 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule